// File: doc/BRIEF.md
# Two-Press Instruction Loader

This block builds one 16-bit instruction for a small serial processor out of two bytes that an operator sets on an 8-bit switch bus and commits with a pushbutton. The button passes through a two-flop synchroniser, and the block loads only on a rising edge of the synchronised button. It ignores the button's level.

The first accepted press takes a 4-bit opcode from the low half of the bus and the first four body bits from the high half. The second accepted press fills the upper eight body bits. The register update from the second press comes with a one-clock ready pulse, which tells the processor the instruction is complete. An internal phase flag records which press comes next.

While the processor reports that it is busy, presses are dropped and change nothing. The reset is synchronous and active low.

Top module: `twopress_loader`

## Requirements
- R1: While reset is low at a clock edge, that edge clears `op`, `body` and `ready`, and it clears the phase so that the next accepted press counts as a first press.
- R2: A first press loads `op` with `din[3:0]` and `body[3:0]` with `din[7:4]`. It leaves `body[11:4]` unchanged and does not raise `ready`.
- R3: A second press loads `body[11:4]` with `din[7:0]` and leaves `op` and `body[3:0]` unchanged.
- R4: `ready` goes high at the same edge that stores the second press and stays high for exactly one clock. It never goes high after a first press.
- R5: A button held high for many clocks gives exactly one load. Another load needs a release followed by a new rise.
- R6: Accepted presses alternate between first and second. A third press after a complete pair acts as a first press again.
- R7: A press whose load edge finds `busy` high is ignored. No output changes and the phase stays as it was.
- R8: When `btn` rises between two clock edges, the load takes place at the third rising edge after that. The outputs are unchanged after the second edge.
- R9: A reset that comes after a first press cancels the half-built instruction, and the next press is a first press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Switch data bus |
| btn | input | 1 | Pushbutton that commits the bus value (asynchronous) |
| busy | input | 1 | High while the processor executes; presses are then ignored |
| op | output | 4 | Opcode from the first press |
| body | output | 12 | Instruction body: bits 3:0 from the first press, bits 11:4 from the second |
| ready | output | 1 | One-clock pulse when a full instruction is held |

## Verification
A detected button edge and a high `busy` can meet at the same load edge. The block must then let `busy` win and leave both the registers and the phase untouched. The bench provokes this by raising `busy` together with the button and holding it through the capture edge. It does this once in each phase. It judges the outcome at the ports: outputs stay unchanged, no `ready` pulse appears, and the next press without `busy` still lands in the phase that was expected before the dropped press.

// File: rtl/twopress_loader.sv
module twopress_loader #(
  parameter int DW  = 8,
  parameter int OPW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         din,
  input  logic                  btn,
  input  logic                  busy,
  output logic [OPW-1:0]        op,
  output logic [2*DW-OPW-1:0]   body,
  output logic                  ready
);
  localparam int BW = 2*DW - OPW;
  localparam int LW = DW - OPW;

  logic [1:0] sync_q;
  logic       seen_q;
  logic       phase_q;
  logic       take;

  assign take = sync_q[1] & ~seen_q & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      seen_q  <= 1'b0;
      phase_q <= 1'b0;
      op      <= '0;
      body    <= '0;
      ready   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn};
      seen_q <= sync_q[1];
      ready  <= take & phase_q;
      if (take) begin
        if (!phase_q) begin
          op          <= din[OPW-1:0];
          body[LW-1:0] <= din[DW-1:OPW];
          phase_q     <= 1'b1;
        end else begin
          body[BW-1:LW] <= din;
          phase_q       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/twopress_loader_chk.sv
module twopress_loader_chk #(
  parameter int OPW = 4,
  parameter int BW  = 12,
  parameter int LW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic [OPW-1:0] op,
  input logic [BW-1:0]  body,
  input logic           ready,
  input logic           phase,
  input logic           fire
);
  assert_ready_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_ready_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !phase);

  assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op) && $stable(body) && $stable(phase)));

  assert_first_keeps_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase) |-> ($stable(body[BW-1:LW]) && !ready));

  assert_second_keeps_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($stable(op) && $stable(body[LW-1:0])));

  assert_one_take_per_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

bind twopress_loader twopress_loader_chk #(.OPW(OPW), .BW(BW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op(op), .body(body),
  .ready(ready), .phase(phase_q), .fire(take)
);

// File: tb/test_twopress_loader.sv
module test_twopress_loader;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = '0;
  logic        btn = 1'b0;
  logic        busy = 1'b0;
  logic [3:0]  op;
  logic [11:0] body;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  twopress_loader i_twopress_loader (
    .clk(clk), .rst_n(rst_n), .din(din), .btn(btn), .busy(busy),
    .op(op), .body(body), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press(input logic [7:0] d, input logic b);
    @(negedge clk);
    din = d; busy = b; btn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic lift(input int hold);
    repeat (hold) @(posedge clk);
    @(negedge clk);
    btn = 1'b0;
    @(posedge clk); #1;
    check("R4 ready low after one clock", ready, 0);
    busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R1 reset op", op, 0);
    check("R1 reset body", body, 0);
    check("R1 reset ready", ready, 0);
  endtask

  task automatic t_pair;
    press(8'hA5, 1'b0);
    check("R2 first press op", op, 4'h5);
    check("R2 first press body", body, 12'h00A);
    check("R2 no ready after first", ready, 0);
    lift(0);
    press(8'h3C, 1'b0);
    check("R3 second press body", body, 12'h3CA);
    check("R3 op kept", op, 4'h5);
    check("R4 ready pulse", ready, 1);
    lift(0);
  endtask

  task automatic t_held;
    press(8'h71, 1'b0);
    check("R5 held first op", op, 4'h1);
    check("R5 held first body", body, 12'h3C7);
    lift(20);
    check("R5 held no extra load", ready, 0);
    check("R5 held body kept", body, 12'h3C7);
    press(8'h9E, 1'b0);
    check("R5 next press is second", ready, 1);
    check("R5 second body", body, 12'h9E7);
    lift(0);
  endtask

  task automatic t_three;
    press(8'h12, 1'b0); lift(0);
    press(8'h34, 1'b0); lift(0);
    press(8'h56, 1'b0);
    check("R6 third press op", op, 4'h6);
    check("R6 third press body", body, 12'h345);
    check("R6 third press no ready", ready, 0);
    lift(0);
    press(8'h78, 1'b0);
    check("R6 fourth press ready", ready, 1);
    check("R6 fourth press body", body, 12'h785);
    lift(0);
  endtask

  task automatic t_busy;
    press(8'hFF, 1'b1);
    check("R7 busy first op", op, 4'h6);
    check("R7 busy first body", body, 12'h785);
    check("R7 busy first ready", ready, 0);
    lift(0);
    press(8'h4B, 1'b0);
    check("R7 phase kept first op", op, 4'hB);
    check("R7 phase kept first body", body, 12'h784);
    check("R7 phase kept first ready", ready, 0);
    lift(0);
    press(8'hEE, 1'b1);
    check("R7 busy second ready", ready, 0);
    check("R7 busy second body", body, 12'h784);
    lift(0);
    press(8'hC3, 1'b0);
    check("R7 phase kept second ready", ready, 1);
    check("R7 phase kept second body", body, 12'hC34);
    lift(0);
  endtask

  task automatic t_latency_reset;
    @(negedge clk);
    din = 8'h21; btn = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R8 no load after two edges", op, 4'hB);
    @(posedge clk); #1;
    check("R8 load at third edge", op, 4'h1);
    lift(0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R9 reset op", op, 0);
    check("R9 reset body", body, 0);
    press(8'h87, 1'b0);
    check("R9 first after reset op", op, 4'h7);
    check("R9 first after reset body", body, 12'h008);
    check("R9 first after reset ready", ready, 0);
    lift(0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_pair();
    t_held();
    t_three();
    t_busy();
    t_latency_reset();
    finish_run();
  end
endmodule